// File: doc/BRIEF.md
# Per-Channel Piecewise-Linear Transfer Curve

This block applies a programmable transfer curve to the red, green and blue components of a display layer's pixel stream. The curve can either linearize the pixels or encode them. Each colour channel has its own table of NPTS breakpoints. Each pixel component is split into a segment number (its upper bits) and a fraction (its lower bits). The output is the linear interpolation between the two breakpoints that bound that segment. A channel whose enable is clear passes its input through unchanged.

Software loads the tables with two register writes. A write to the position port rewinds an internal stream counter. Each write to the data port then delivers two 16-bit entries. All tables form one continuous stream: every red entry, then every green entry, then every blue entry. With an odd table size, a red/green word is shared and the final blue entry arrives alone. Loads go into a shadow copy. The active tables take that copy only at a frame-start strobe, and only after the stream has been fully written. This keeps a frame from being drawn with a half-loaded curve. The default build is the 33-point linearizing curve. A 41-point, 10-bit encoding curve is the same block with different parameters.

Top module: `tc_curve_lut`

## Requirements
- R1: After synchronous reset, out_valid and all three outputs are 0, every channel is in bypass and every active and shadow entry is 0.
- R2: A write to the position port (pos_we) sets the stream position to entry 0 whatever value is on wdata, and it takes priority over a data write in the same cycle.
- R3: A data write (data_we) stores wdata[15:0] at the current stream position and wdata[31:16] at the next one, then advances the position by two.
- R4: Stream position q addresses channel q/NPTS (0 red, 1 green, 2 blue), entry q%NPTS. The last word of an odd-length stream keeps only its low half. Data writes after all 3*NPTS entries have been written change nothing.
- R5: On a frame_start cycle, the shadow tables are copied to the active tables only if the position has reached 3*NPTS since the last position-port write. Otherwise the active tables stay as they are.
- R6: A ctrl_we write latches the red, green and blue enables from wdata[EN_LSB], wdata[EN_LSB+1] and wdata[EN_LSB+2]. When USE_MASTER is 1, wdata[31] is also latched as a master enable, and all channels bypass while it is clear.
- R7: A channel in bypass outputs its IN_W-bit input zero-extended to 16 bits.
- R8: An enabled channel with segment s = x >> F (F = IN_W - clog2(NPTS-1)) below NPTS-1 and fraction f = x mod 2^F outputs lo + floor((hi - lo) * f / 2^F), where lo = entry s and hi = entry s+1, treated as unsigned. The difference is signed, so falling curves work.
- R9: An enabled channel whose segment number is NPTS-1 or more outputs the channel's last entry.
- R10: The outputs register the result of a pix_valid cycle one cycle later, with out_valid high. On cycles without pix_valid, out_valid is low and the outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_we | input | 1 | Write strobe for the stream position port |
| data_we | input | 1 | Write strobe for the packed data port |
| ctrl_we | input | 1 | Write strobe for the enable register |
| wdata | input | 32 | Write data shared by all three ports |
| frame_start | input | 1 | Frame boundary strobe; commits a complete load |
| pix_valid | input | 1 | Pixel input qualifier |
| pix_r | input | IN_W | Red component in |
| pix_g | input | IN_W | Green component in |
| pix_b | input | IN_W | Blue component in |
| out_valid | output | 1 | Output qualifier, one cycle after pix_valid |
| out_r | output | 16 | Red component out |
| out_g | output | 16 | Green component out |
| out_b | output | 16 | Blue component out |

## Verification
The bench builds two copies side by side. The first uses the defaults: 33 points, a 14-bit input and enables at bits 29:27 gated by a master bit. Here the 32 segments tile the input exactly, and the ramp from 0 to 0x4000 in steps of 0x200 maps every input onto itself. The second uses 41 points, a 12-bit input and ungated enables at bits 31:29. This build has 64 segment codes but only 40 real segments, so it reaches the saturation region, the shared red/green word and the lone final blue entry. That last entry is the 123rd entry of an odd-length stream.

// File: rtl/tc_pkg.sv
package tc_pkg;

    localparam int ENT_W  = 16;
    localparam int NCH    = 3;
    localparam int WORD_W = 32;

    typedef logic [ENT_W-1:0] entry_t;

    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2
    } chan_e;

    typedef struct packed {
        logic            master;
        logic [NCH-1:0]  en;
    } ctrl_t;

    function automatic int seg_bits(input int npts);
        return $clog2(npts - 1);
    endfunction

endpackage

// File: rtl/tc_loader.sv
module tc_loader
    import tc_pkg::*;
#(
    parameter int NPTS = 33
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        pos_we,
    input  logic                        data_we,
    input  logic [WORD_W-1:0]           wdata,
    output entry_t [NCH*NPTS-1:0]       shadow,
    output logic                        complete
);
    localparam int TOTAL = NCH * NPTS;
    localparam int POS_W = $clog2(TOTAL + 2);
    localparam logic [POS_W-1:0] TOTAL_V = POS_W'(TOTAL);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_nxt;
    logic [POS_W-1:0] pos_p1;
    logic             accept;

    assign accept   = data_we && !pos_we && (pos_q < TOTAL_V);
    assign pos_p1   = pos_q + POS_W'(1);
    assign pos_nxt  = (pos_q + POS_W'(2) > TOTAL_V) ? TOTAL_V : pos_q + POS_W'(2);
    assign complete = (pos_q == TOTAL_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (pos_we) begin
            pos_q <= '0;
        end else if (accept) begin
            pos_q <= pos_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else if (accept) begin
            for (int q = 0; q < TOTAL; q++) begin
                if (pos_q == POS_W'(q)) begin
                    shadow[q] <= wdata[ENT_W-1:0];
                end else if (pos_p1 == POS_W'(q)) begin
                    shadow[q] <= wdata[WORD_W-1:ENT_W];
                end
            end
        end
    end

    // R4
    pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pos_q <= TOTAL_V);

    // R2
    pos_rewind_chk: assert property (@(posedge clk) disable iff (rst)
        pos_we |=> (pos_q == '0));

    // R3
    pos_step_chk: assert property (@(posedge clk) disable iff (rst)
        (data_we && !pos_we && (pos_q + POS_W'(2) <= TOTAL_V))
        |=> (pos_q == $past(pos_q) + POS_W'(2)));

    // R3
    low_half_chk: assert property (@(posedge clk) disable iff (rst)
        (data_we && !pos_we && (pos_q == '0)) |=> (shadow[0] == $past(wdata[ENT_W-1:0])));

endmodule

// File: rtl/tc_bank.sv
module tc_bank
    import tc_pkg::*;
#(
    parameter int NPTS = 33
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        frame_start,
    input  logic                        complete,
    input  entry_t [NCH*NPTS-1:0]       shadow,
    output entry_t [NCH*NPTS-1:0]       active
);
    logic take;

    assign take = frame_start && complete;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
        end else if (take) begin
            active <= shadow;
        end
    end

    // R5
    commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (active == $past(shadow)));

    // R5
    commit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(active));

endmodule

// File: rtl/tc_interp.sv
module tc_interp
    import tc_pkg::*;
#(
    parameter int NPTS = 33,
    parameter int IN_W = 14
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    pix_valid,
    input  logic [IN_W-1:0]         x,
    input  entry_t [NPTS-1:0]       tbl,
    output entry_t                  y
);
    localparam int SEG_W  = seg_bits(NPTS);
    localparam int FRAC_W = IN_W - SEG_W;
    localparam int IDX_W  = $clog2(NPTS);
    localparam int PW     = ENT_W + FRAC_W + 2;
    localparam logic [SEG_W:0]   LAST_V   = (SEG_W + 1)'(NPTS - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPTS - 1);

    logic [SEG_W-1:0]          seg;
    logic [FRAC_W-1:0]         frac;
    logic                      sat;
    logic [IDX_W-1:0]          idx_lo;
    logic [IDX_W-1:0]          idx_hi;
    entry_t                    lo;
    entry_t                    hi;
    logic signed [ENT_W:0]     diff;
    logic signed [PW-1:0]      prod;
    logic signed [PW-1:0]      step;
    entry_t                    curve;
    entry_t                    pass;

    always_comb begin
        seg    = x[IN_W-1 -: SEG_W];
        frac   = x[FRAC_W-1:0];
        sat    = ({1'b0, seg} >= LAST_V);
        idx_lo = sat ? LAST_IDX : IDX_W'(seg);
        idx_hi = sat ? LAST_IDX : IDX_W'(seg) + IDX_W'(1);
        lo     = tbl[idx_lo];
        hi     = tbl[idx_hi];
        diff   = $signed({1'b0, hi}) - $signed({1'b0, lo});
        prod   = PW'(diff) * PW'($signed({1'b0, frac}));
        step   = prod >>> FRAC_W;
        curve  = lo + step[ENT_W-1:0];
        pass   = ENT_W'(x);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y <= '0;
        end else if (pix_valid) begin
            y <= en ? curve : pass;
        end
    end

    // R7
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !en) |=> (y == ENT_W'($past(x))));

    // R8
    span_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && en && !sat) |=>
        (((y >= $past(lo)) && (y <= $past(hi))) || ((y <= $past(lo)) && (y >= $past(hi)))));

    // R9
    sat_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && en && sat) |=> (y == $past(tbl[NPTS-1])));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> $stable(y));

endmodule

// File: rtl/tc_curve_lut.sv
module tc_curve_lut
    import tc_pkg::*;
#(
    parameter int NPTS       = 33,
    parameter int IN_W       = 14,
    parameter int EN_LSB     = 27,
    parameter bit USE_MASTER = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pos_we,
    input  logic                 data_we,
    input  logic                 ctrl_we,
    input  logic [31:0]          wdata,
    input  logic                 frame_start,
    input  logic                 pix_valid,
    input  logic [IN_W-1:0]      pix_r,
    input  logic [IN_W-1:0]      pix_g,
    input  logic [IN_W-1:0]      pix_b,
    output logic                 out_valid,
    output logic [15:0]          out_r,
    output logic [15:0]          out_g,
    output logic [15:0]          out_b
);
    localparam int TOTAL = NCH * NPTS;

    entry_t [TOTAL-1:0]   shadow;
    entry_t [TOTAL-1:0]   active;
    logic                 complete;
    ctrl_t                ctrl_q;
    logic [NCH-1:0]       en_eff;
    logic [IN_W-1:0]      pix   [NCH];
    entry_t               res   [NCH];

    assign pix[CH_RED]   = pix_r;
    assign pix[CH_GREEN] = pix_g;
    assign pix[CH_BLUE]  = pix_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= pix_valid;
            if (ctrl_we) begin
                ctrl_q.en     <= wdata[EN_LSB +: NCH];
                ctrl_q.master <= wdata[31];
            end
        end
    end

    generate
        if (USE_MASTER) begin : g_master
            assign en_eff = ctrl_q.master ? ctrl_q.en : '0;
        end else begin : g_free
            assign en_eff = ctrl_q.en;
        end
    endgenerate

    tc_loader #(.NPTS(NPTS)) loader_i (
        .clk      (clk),
        .rst      (rst),
        .pos_we   (pos_we),
        .data_we  (data_we),
        .wdata    (wdata),
        .shadow   (shadow),
        .complete (complete)
    );

    tc_bank #(.NPTS(NPTS)) bank_i (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .complete    (complete),
        .shadow      (shadow),
        .active      (active)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tc_interp #(.NPTS(NPTS), .IN_W(IN_W)) interp_i (
            .clk       (clk),
            .rst       (rst),
            .en        (en_eff[c]),
            .pix_valid (pix_valid),
            .x         (pix[c]),
            .tbl       (active[c*NPTS +: NPTS]),
            .y         (res[c])
        );
    end

    assign out_r = res[CH_RED];
    assign out_g = res[CH_GREEN];
    assign out_b = res[CH_BLUE];

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> out_valid);

    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !out_valid);

    // R6
    ctrl_latch_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> (ctrl_q.en == $past(wdata[EN_LSB +: NCH])));

endmodule

// File: tb/tc_curve_lut_tb.sv
`timescale 1ns/1ps
module tc_curve_lut_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  pos_we = '0;
    logic [1:0]  data_we = '0;
    logic [1:0]  ctrl_we = '0;
    logic [31:0] wdata = '0;
    logic        frame_start = 1'b0;
    logic        pix_valid = 1'b0;
    logic [13:0] pr = '0, pg = '0, pb = '0;

    logic        ov_a, ov_b;
    logic [15:0] or_a, og_a, ob_a, or_b, og_b, ob_b;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    int sh  [2][0:122];
    int ac  [2][0:122];
    int pos [2];
    logic [31:0] ctl [2];
    int expo [2][3];
    bit expv [2];
    int tv  [0:122];

    always #2 clk = ~clk;

    tc_curve_lut dut_i (
        .clk(clk), .rst(rst), .pos_we(pos_we[0]), .data_we(data_we[0]),
        .ctrl_we(ctrl_we[0]), .wdata(wdata), .frame_start(frame_start),
        .pix_valid(pix_valid), .pix_r(pr), .pix_g(pg), .pix_b(pb),
        .out_valid(ov_a), .out_r(or_a), .out_g(og_a), .out_b(ob_a)
    );

    tc_curve_lut #(.NPTS(41), .IN_W(12), .EN_LSB(29), .USE_MASTER(1'b0)) dut41_i (
        .clk(clk), .rst(rst), .pos_we(pos_we[1]), .data_we(data_we[1]),
        .ctrl_we(ctrl_we[1]), .wdata(wdata), .frame_start(frame_start),
        .pix_valid(pix_valid), .pix_r(pr[11:0]), .pix_g(pg[11:0]), .pix_b(pb[11:0]),
        .out_valid(ov_b), .out_r(or_b), .out_g(og_b), .out_b(ob_b)
    );

    function automatic int npts(int k); return (k == 1) ? 41 : 33; endfunction
    function automatic int inw(int k);  return (k == 1) ? 12 : 14; endfunction
    function automatic int enlsb(int k); return (k == 1) ? 29 : 27; endfunction

    function automatic int curve(int k, int c, int x);
        int n = npts(k);
        int fw = inw(k) - $clog2(n - 1);
        int s = x >> fw;
        int f = x & ((1 << fw) - 1);
        int lo, hi;
        if (s >= n - 1) return ac[k][c*n + n - 1];
        lo = ac[k][c*n + s];
        hi = ac[k][c*n + s + 1];
        return lo + (((hi - lo) * f) >>> fw);
    endfunction

    function automatic int got(int k, int c);
        if (k == 0) return (c == 0) ? int'(or_a) : (c == 1) ? int'(og_a) : int'(ob_a);
        return (c == 0) ? int'(or_b) : (c == 1) ? int'(og_b) : int'(ob_b);
    endfunction

    task automatic tick();
        int px [3];
        px[0] = int'(pr); px[1] = int'(pg); px[2] = int'(pb);
        for (int k = 0; k < 2; k++) begin
            int n = npts(k);
            int tot = 3 * n;
            bit men = (k == 1) ? 1'b1 : ctl[k][31];
            expv[k] = pix_valid;
            if (pix_valid) begin
                for (int c = 0; c < 3; c++) begin
                    int x = px[c] & ((1 << inw(k)) - 1);
                    expo[k][c] = (ctl[k][enlsb(k) + c] && men) ? curve(k, c, x) : x;
                end
            end
            if (ctrl_we[k]) ctl[k] = wdata;
            if (frame_start && pos[k] == tot)
                for (int q = 0; q < tot; q++) ac[k][q] = sh[k][q];
            if (pos_we[k]) pos[k] = 0;
            else if (data_we[k] && pos[k] < tot) begin
                sh[k][pos[k]] = int'(wdata[15:0]);
                if (pos[k] + 1 < tot) sh[k][pos[k] + 1] = int'(wdata[31:16]);
                pos[k] = (pos[k] + 2 > tot) ? tot : pos[k] + 2;
            end
        end
        @(posedge clk);
        #1;
        for (int k = 0; k < 2; k++) begin
            bit gv = (k == 0) ? ov_a : ov_b;
            checks++;
            if (gv !== expv[k]) begin
                errors++;
                $display("FAIL %s inst%0d out_valid actual %0d expected %0d", cur_req, k, gv, expv[k]);
            end
            for (int c = 0; c < 3; c++) begin
                checks++;
                if (got(k, c) != expo[k][c]) begin
                    errors++;
                    $display("FAIL %s inst%0d ch%0d actual %0h expected %0h",
                             cur_req, k, c, got(k, c), expo[k][c]);
                end
            end
        end
    endtask

    task automatic set_pos(int k, logic [31:0] v);
        wdata = v; pos_we[k] = 1'b1; tick(); pos_we[k] = 1'b0;
    endtask

    task automatic set_ctrl(int k, logic [31:0] v);
        wdata = v; ctrl_we[k] = 1'b1; tick(); ctrl_we[k] = 1'b0;
    endtask

    // sends words first..first+count-1 of the stream held in tv
    task automatic send_words(int k, int first, int count);
        int tot = 3 * npts(k);
        for (int w = first; w < first + count; w++) begin
            logic [15:0] lo = (2*w < tot) ? 16'(tv[2*w]) : 16'hA5A5;
            logic [15:0] hi = (2*w + 1 < tot) ? 16'(tv[2*w + 1]) : 16'hBEEF;
            wdata = {hi, lo}; data_we[k] = 1'b1; tick(); data_we[k] = 1'b0;
        end
    endtask

    task automatic frame();
        frame_start = 1'b1; tick(); frame_start = 1'b0;
    endtask

    task automatic pix(int r, int g, int b);
        pr = 14'(r); pg = 14'(g); pb = 14'(b); pix_valid = 1'b1; tick(); pix_valid = 1'b0;
    endtask

    task automatic sweep(int seed);
        pix(0, 14'h3FFF, 14'h0200);
        pix(14'h01FF, 14'h0A00, 14'h0FFF);
        pix(14'h0A00, 14'h0FC0, 14'h2BCD);
        for (int i = 0; i < 24; i++)
            pix((i*7919 + seed) & 16'h3FFF, (i*4099 + 3*seed) & 16'h3FFF, (i*613 + 977) & 16'h3FFF);
    endtask

    task automatic fill_identity(int k);
        int n = npts(k);
        for (int q = 0; q < 3*n; q++) begin
            int i = q % n;
            if (k == 0) tv[q] = i * 'h200;
            else begin
                int v = (i > 4) ? (i - 4) * 32 : 0;
                tv[q] = (v > 1023) ? 1023 : v;
            end
        end
    endtask

    task automatic fill_pattern(int k, int seed);
        for (int q = 0; q < 3*npts(k); q++) tv[q] = (q*2731 + seed*40503 + 19) & 16'hFFFF;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            pos[k] = 0; ctl[k] = '0; expv[k] = 1'b0;
            for (int c = 0; c < 3; c++) expo[k][c] = 0;
            for (int q = 0; q < 123; q++) begin sh[k][q] = 0; ac[k][q] = 0; end
        end
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        cur_req = "R1";
        tick();
        cur_req = "R7 bypass after reset";
        sweep(11);

        cur_req = "R6 enables with zero tables";
        set_ctrl(0, 32'h3800_0000 | 32'h8000_0000);
        set_ctrl(1, 32'hE000_0000);
        sweep(5);

        cur_req = "R5 partial load no commit";
        fill_identity(0); set_pos(0, 0); send_words(0, 0, 20);
        fill_identity(1); set_pos(1, 0); send_words(1, 0, 30);
        frame();
        sweep(23);

        cur_req = "R3 R4 R8 identity curves";
        fill_identity(0); send_words(0, 20, 30);
        fill_identity(1); send_words(1, 30, 32);
        frame();
        sweep(71);

        cur_req = "R2 rewind mid load";
        fill_pattern(0, 1); set_pos(0, 32'h0000_1234); send_words(0, 0, 10);
        set_pos(0, 32'hFFFF_FFFF); send_words(0, 0, 50);
        cur_req = "R4 writes past stream end";
        fill_pattern(0, 9); send_words(0, 40, 8);
        fill_pattern(1, 2); set_pos(1, 32'h0000_0003); send_words(1, 0, 66);
        frame();
        cur_req = "R8 R9 falling and saturating curves";
        sweep(131);
        sweep(4001);

        cur_req = "R6 master clear";
        set_ctrl(0, 32'h3800_0000);
        sweep(17);
        cur_req = "R6 single channel enables";
        set_ctrl(0, 32'h8000_0000 | (32'h1 << 28));
        set_ctrl(1, 32'h1 << 29);
        sweep(29);

        cur_req = "R10 idle hold";
        repeat (5) tick();
        pix(14'h1234, 14'h0042, 14'h3F00);
        repeat (3) tick();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule